// File: doc/BRIEF.md
# Row-Column Microprogram Sequencer

This block produces the address of the next microinstruction for a control store of 2^(ROW_W+COL_W) words. With the defaults that is 512 words. The address is held as a row part of ROW_W bits (5 by default) and a column part of COL_W bits (4 by default). Each cycle, a jump-control field from the current microinstruction picks one of eleven jump functions. The chosen function replaces the row, the column, or both. Conditional jumps put a tested condition into the lowest column bit, or a pair of condition bits into the two lowest column bits. The jump then lands on one of two or four neighbouring column addresses.

The tested conditions come from three places: three internal flag registers, the low bits of an external condition bus, and a program latch. The program latch captures that bus on request, so a later microinstruction can do a 16-way dispatch on it. A separate 4-bit flag-control field sets, clears or loads the flags from an external flag input. An optional pipeline register holds the rest of the microinstruction for one cycle. This lets the fetch of the next word overlap the execution of the current one.

Top module: `useq_rowcol`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the address, all three flags, the program latch and the pipeline register. Right after reset, a dispatch jump lands on column 0.
- R2: When `ac_i[6:5]` is 00 (row jump), the next row is `ac_i[4:0]` and the column is kept.
- R3: When `ac_i[6:4]` is 010 (column jump), the next column is `ac_i[3:0]` and the row is kept.
- R4: When `ac_i[6:4]` is 011 (zero-row jump), the next row is 0 and the next column is `ac_i[3:0]`.
- R5: When `ac_i[6:5]` is 10 and `ac_i[4:3]` is k, with k from 0 to 2, the next column is {`ac_i[2:0]`, flag k}. The row is kept. `flags_o[k]` is flag k.
- R6: When `ac_i[6:3]` is 1011 (bus bit test), the next column is {`ac_i[2:0]`, `bus_i[0]`}. The row is kept.
- R7: When `ac_i[6:3]` is 1100 (four-way bus branch), the next column is {`ac_i[2:1]`, `bus_i[1:0]`}. The row is kept.
- R8: When `ac_i[6:3]` is 1101 (dispatch), the next column equals the program latch. The row is kept.
- R9: When `ac_i[6:3]` is 1110 (four-way latch branch), the next column is {`ac_i[2:1]`, latch bits 1:0}. The row is kept.
- R10: When `ac_i[6:3]` is 1111 (stay), the address does not change.
- R11: The program latch loads `bus_i` at an edge where `latch_en_i` is high, and holds its value otherwise.
- R12: Flag control works as follows. `fc_i[3:2]` selects flag 0, 1 or 2, and 3 selects all three. `fc_i[1:0]` picks the operation: 00 hold, 01 load from `flag_in_i`, 10 clear, 11 set. The result shows on `flags_o` after the edge. A jump in the same cycle tests the value the flag had before that edge.
- R13: With PIPE_EN=1, `uword_o` equals the value `uword_i` had one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ac_i | input | ROW_W+2 | Jump-control field of the current microinstruction |
| fc_i | input | 4 | Flag-control field: target in [3:2], operation in [1:0] |
| bus_i | input | COL_W | Condition bus and program latch data |
| latch_en_i | input | 1 | Program latch load enable |
| flag_in_i | input | 1 | Value loaded into the targeted flags by the load operation |
| uword_i | input | PIPE_W | Remaining microinstruction bits from the control store |
| addr_o | output | ROW_W+COL_W | Current microinstruction address, {row, column} |
| flags_o | output | 3 | Flag registers |
| uword_o | output | PIPE_W | Pipelined microinstruction bits |

## Verification
The assertions assume that `rst` is high from time zero until the first rising edge. They also assume that every input is a known 0 or 1 at each edge, since conditions and jump fields feed straight into the address register. The bench drives all inputs at falling edges from a single task, so both assumptions always hold. It sweeps every one of the 128 jump-control codes. Each code is combined with several bus values, flag-control codes, latch enables and flag inputs, so every flag condition and latch value is tested while it also changes.

// File: rtl/useq_pkg.sv
package useq_pkg;
   localparam int NFLAG = 3;

   typedef enum logic [1:0] {
      FOP_HOLD = 2'b00,
      FOP_LOAD = 2'b01,
      FOP_CLR  = 2'b10,
      FOP_SET  = 2'b11
   } flag_op_e;

   typedef enum logic [1:0] {
      JG_ROW  = 2'b00,
      JG_COL  = 2'b01,
      JG_COND = 2'b10,
      JG_MISC = 2'b11
   } jump_grp_e;
endpackage

// File: rtl/useq_nextaddr.sv
module useq_nextaddr #(
   parameter int ROW_W = 5,
   parameter int COL_W = 4
) (
   input  logic [ROW_W+1:0]          ac_i,
   input  logic [ROW_W-1:0]          row_i,
   input  logic [COL_W-1:0]          col_i,
   input  logic [useq_pkg::NFLAG-1:0] flag_i,
   input  logic [1:0]                bus_lo_i,
   input  logic [COL_W-1:0]          latch_i,
   output logic [ROW_W-1:0]          row_o,
   output logic [COL_W-1:0]          col_o
);
   import useq_pkg::*;
   localparam int AC_W = ROW_W + 2;

   jump_grp_e  grp;
   logic [1:0] sub;
   logic       cond;

   assign grp = jump_grp_e'(ac_i[AC_W-1:AC_W-2]);
   assign sub = ac_i[ROW_W-1:ROW_W-2];

   always_comb begin
      case (sub)
         2'd0:    cond = flag_i[0];
         2'd1:    cond = flag_i[1];
         2'd2:    cond = flag_i[2];
         default: cond = bus_lo_i[0];
      endcase
   end

   always_comb begin
      row_o = row_i;
      col_o = col_i;
      case (grp)
         JG_ROW: row_o = ac_i[ROW_W-1:0];
         JG_COL: begin
            col_o = ac_i[COL_W-1:0];
            if (ac_i[ROW_W-1]) row_o = '0;
         end
         JG_COND: col_o = {ac_i[COL_W-2:0], cond};
         default: begin
            case (sub)
               2'd0:    col_o = {ac_i[COL_W-2:1], bus_lo_i};
               2'd1:    col_o = latch_i;
               2'd2:    col_o = {ac_i[COL_W-2:1], latch_i[1:0]};
               default: col_o = col_i;
            endcase
         end
      endcase
   end
endmodule

// File: rtl/useq_flags.sv
module useq_flags (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [3:0]                fc_i,
   input  logic                      flag_in_i,
   output logic [useq_pkg::NFLAG-1:0] flags_o
);
   import useq_pkg::*;

   flag_op_e op;
   assign op = flag_op_e'(fc_i[1:0]);

   for (genvar k = 0; k < NFLAG; k++) begin : g_flag
      logic hit;
      assign hit = (fc_i[3:2] == 2'(k)) || (fc_i[3:2] == 2'd3);
      always_ff @(posedge clk) begin
         if (rst) flags_o[k] <= 1'b0;
         else if (hit) begin
            case (op)
               FOP_LOAD: flags_o[k] <= flag_in_i;
               FOP_CLR:  flags_o[k] <= 1'b0;
               FOP_SET:  flags_o[k] <= 1'b1;
               default:  flags_o[k] <= flags_o[k];
            endcase
         end
      end
   end

   // R12: hold operation leaves every flag unchanged
   p_flag_hold_r12: assert property (@(posedge clk) disable iff (rst)
      (fc_i[1:0] == 2'b00) |=> $stable(flags_o));
   // R12: set on all targets raises every flag
   p_flag_set_all_r12: assert property (@(posedge clk) disable iff (rst)
      (fc_i == 4'b1111) |=> (flags_o == '1));
   // R12: clear on all targets drops every flag
   p_flag_clr_all_r12: assert property (@(posedge clk) disable iff (rst)
      (fc_i == 4'b1110) |=> (flags_o == '0));
endmodule

// File: rtl/useq_pipe.sv
module useq_pipe #(
   parameter int W  = 8,
   parameter bit EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (EN) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) q_o <= '0;
         else     q_o <= d_i;
      end
      // R13: one-cycle delay of the microinstruction bits
      p_pipe_delay_r13: assert property (@(posedge clk) disable iff (rst)
         1'b1 |=> (q_o == $past(d_i)));
   end else begin : g_wire
      assign q_o = d_i;
   end
endmodule

// File: rtl/useq_rowcol.sv
module useq_rowcol #(
   parameter int ROW_W    = 5,
   parameter int COL_W    = 4,
   parameter int PIPE_W   = 8,
   parameter bit PIPE_EN  = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [ROW_W+1:0]          ac_i,
   input  logic [3:0]                fc_i,
   input  logic [COL_W-1:0]          bus_i,
   input  logic                      latch_en_i,
   input  logic                      flag_in_i,
   input  logic [PIPE_W-1:0]         uword_i,
   output logic [ROW_W+COL_W-1:0]    addr_o,
   output logic [useq_pkg::NFLAG-1:0] flags_o,
   output logic [PIPE_W-1:0]         uword_o
);
   localparam int AW = ROW_W + COL_W;

   if (COL_W < 3 || COL_W >= ROW_W) begin : g_bad_geom
      $error("useq_rowcol: COL_W must be at least 3 and below ROW_W");
   end
   if (PIPE_W < 1) begin : g_bad_pipe
      $error("useq_rowcol: PIPE_W must be positive");
   end

   logic [ROW_W-1:0] row_q, row_n;
   logic [COL_W-1:0] col_q, col_n;
   logic [COL_W-1:0] latch_q;

   useq_nextaddr #(.ROW_W(ROW_W), .COL_W(COL_W)) u_next (
      .ac_i     (ac_i),
      .row_i    (row_q),
      .col_i    (col_q),
      .flag_i   (flags_o),
      .bus_lo_i (bus_i[1:0]),
      .latch_i  (latch_q),
      .row_o    (row_n),
      .col_o    (col_n)
   );

   useq_flags u_flags (
      .clk       (clk),
      .rst       (rst),
      .fc_i      (fc_i),
      .flag_in_i (flag_in_i),
      .flags_o   (flags_o)
   );

   useq_pipe #(.W(PIPE_W), .EN(PIPE_EN)) u_pipe (
      .clk (clk),
      .rst (rst),
      .d_i (uword_i),
      .q_o (uword_o)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         row_q   <= '0;
         col_q   <= '0;
         latch_q <= '0;
      end else begin
         row_q <= row_n;
         col_q <= col_n;
         if (latch_en_i) latch_q <= bus_i;
      end
   end

   assign addr_o = {row_q, col_q};

   // R1: reset returns the address to row 0, column 0
   p_reset_addr_r1: assert property (@(posedge clk)
      rst |=> (addr_o == '0));
   // R2: row jump loads the row and keeps the column
   p_row_jump_r2: assert property (@(posedge clk) disable iff (rst)
      (ac_i[ROW_W+1:ROW_W] == 2'b00) |=>
      (addr_o[AW-1:COL_W] == $past(ac_i[ROW_W-1:0])) &&
      (addr_o[COL_W-1:0] == $past(addr_o[COL_W-1:0])));
   // R3: column jump keeps the row
   p_col_jump_r3: assert property (@(posedge clk) disable iff (rst)
      (ac_i[ROW_W+1:ROW_W-1] == 3'b010) |=>
      (addr_o[COL_W-1:0] == $past(ac_i[COL_W-1:0])) &&
      (addr_o[AW-1:COL_W] == $past(addr_o[AW-1:COL_W])));
   // R8: dispatch takes the column from the program latch
   p_dispatch_r8: assert property (@(posedge clk) disable iff (rst)
      (ac_i[ROW_W+1:ROW_W-2] == 4'b1101) |=>
      (addr_o[COL_W-1:0] == $past(latch_q)));
   // R10: stay keeps the whole address
   p_stay_r10: assert property (@(posedge clk) disable iff (rst)
      (ac_i[ROW_W+1:ROW_W-2] == 4'b1111) |=> $stable(addr_o));
   // R11: latch loads the bus when enabled and holds otherwise
   p_latch_load_r11: assert property (@(posedge clk) disable iff (rst)
      latch_en_i |=> (latch_q == $past(bus_i)));
   p_latch_hold_r11: assert property (@(posedge clk) disable iff (rst)
      !latch_en_i |=> $stable(latch_q));
endmodule

// File: tb/useq_rowcol_test.sv
module useq_rowcol_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [6:0] ac_i = '0;
   logic [3:0] fc_i = '0;
   logic [3:0] bus_i = '0;
   logic       latch_en_i = 1'b0;
   logic       flag_in_i = 1'b0;
   logic [7:0] uword_i = '0;
   logic [8:0] addr_o;
   logic [2:0] flags_o;
   logic [7:0] uword_o;

   int checks = 0;
   int failures = 0;

   logic [4:0] m_row = '0;
   logic [3:0] m_col = '0;
   logic [2:0] m_flags = '0;
   logic [3:0] m_latch = '0;

   useq_rowcol uut (
      .clk(clk), .rst(rst), .ac_i(ac_i), .fc_i(fc_i), .bus_i(bus_i),
      .latch_en_i(latch_en_i), .flag_in_i(flag_in_i), .uword_i(uword_i),
      .addr_o(addr_o), .flags_o(flags_o), .uword_o(uword_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input logic [8:0] act, input logic [8:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic string jtag(input logic [6:0] ac);
      if (ac[6:5] == 2'b00) return "R2 row jump";
      if (ac[6:4] == 3'b010) return "R3 column jump";
      if (ac[6:4] == 3'b011) return "R4 zero-row jump";
      if (ac[6:3] == 4'b1011) return "R6 bus bit test";
      if (ac[6:5] == 2'b10) return "R5 flag test";
      if (ac[6:3] == 4'b1100) return "R7 four-way bus";
      if (ac[6:3] == 4'b1101) return "R8 R11 dispatch";
      if (ac[6:3] == 4'b1110) return "R9 four-way latch";
      return "R10 stay";
   endfunction

   // One clocked step: inputs applied at the falling edge, model advanced,
   // outputs sampled 1 time unit after the rising edge.
   task automatic step(input logic [6:0] ac, input logic [3:0] fc, input logic [3:0] bus,
                       input logic len, input logic fin, input logic [7:0] uw);
      logic [4:0] nr;
      logic [3:0] nc;
      logic [2:0] nf;
      logic       cnd;
      ac_i = ac; fc_i = fc; bus_i = bus; latch_en_i = len; flag_in_i = fin; uword_i = uw;
      nr = m_row; nc = m_col;
      cnd = (ac[4:3] == 2'd3) ? bus[0] : m_flags[ac[4:3]];
      case (ac[6:5])
         2'b00: nr = ac[4:0];
         2'b01: begin nc = ac[3:0]; if (ac[4]) nr = 5'd0; end
         2'b10: nc = {ac[2:0], cnd};
         default: case (ac[4:3])
            2'd0: nc = {ac[2:1], bus[1:0]};
            2'd1: nc = m_latch;
            2'd2: nc = {ac[2:1], m_latch[1:0]};
            default: nc = m_col;
         endcase
      endcase
      nf = m_flags;
      for (int k = 0; k < 3; k++) begin
         if (fc[3:2] == 2'(k) || fc[3:2] == 2'd3) begin
            case (fc[1:0])
               2'b01: nf[k] = fin;
               2'b10: nf[k] = 1'b0;
               2'b11: nf[k] = 1'b1;
               default: nf[k] = m_flags[k];
            endcase
         end
      end
      m_row = nr; m_col = nc; m_flags = nf;
      if (len) m_latch = bus;
      @(posedge clk); #1;
      check(addr_o, {m_row, m_col}, jtag(ac));
      check({6'd0, flags_o}, {6'd0, m_flags}, "R12 flags");
      check({1'b0, uword_o}, {1'b0, uw}, "R13 pipeline");
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1'b1; ac_i = 7'b1111000; fc_i = '0; latch_en_i = 1'b0;
      @(posedge clk); #1;
      rst = 1'b0;
      m_row = '0; m_col = '0; m_flags = '0; m_latch = '0;
      check(addr_o, 9'd0, "R1 reset address");
      check({6'd0, flags_o}, 9'd0, "R1 reset flags");
      check({1'b0, uword_o}, 9'd0, "R1 reset pipeline");
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R1: latch cleared by reset, dispatch goes to column 0
      step(7'b1101000, 4'b0000, 4'hA, 1'b0, 1'b0, 8'h11);
      // R11: load latch, then hold it while the bus changes
      step(7'b1111000, 4'b0000, 4'h9, 1'b1, 1'b0, 8'h22);
      step(7'b1111000, 4'b0000, 4'h6, 1'b0, 1'b0, 8'h33);
      step(7'b1101000, 4'b0000, 4'h3, 1'b0, 1'b0, 8'h44);
      // R12: flag 0 set in the same cycle as its test: the test sees the old 0
      step(7'b1000101, 4'b0011, 4'h0, 1'b0, 1'b0, 8'h55);
      step(7'b1000101, 4'b0000, 4'h0, 1'b0, 1'b0, 8'h66);
      // R5/R12: load flag 2 from the flag input, then test it
      step(7'b1010011, 4'b1001, 4'h0, 1'b0, 1'b1, 8'h77);
      step(7'b1010011, 4'b1110, 4'h0, 1'b0, 1'b0, 8'h88);
      // Sweep every jump code against several buses, flag ops and latch enables
      for (int a = 0; a < 128; a++) begin
         for (int b = 0; b < 16; b += 5) begin
            logic [6:0] av;
            logic [3:0] bv;
            logic [3:0] fv;
            av = a[6:0]; bv = b[3:0];
            fv = 4'((a + b) % 16);
            step(av, fv, bv, bv[2], av[0] ^ bv[1], 8'((a * 3 + b) % 256));
         end
      end
      // R1: reset from a busy state
      do_reset();
      step(7'b1101000, 4'b0000, 4'h5, 1'b0, 1'b0, 8'h99);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule